// File: doc/BRIEF.md
# Hardware Monitor Alarm Interrupt Controller

This block gathers alarm conditions from a hardware monitor and turns them into sticky status bits, a software-visible enable mask, and one active-low system management interrupt line. Voltage channels raise an alarm when a sample falls outside its programmed window. A temperature channel raises an alarm above a high limit and keeps it until the reading drops below a lower hysteresis limit. Each fan raises a fault only when its tachometer count stays above the expected count while its PWM drive is at full duty for longer than a programmable fault time.

Status bits are sticky. Software clears them by writing ones to them. A hardware event that lands in the same cycle as the clear keeps its bit set. The interrupt line is low while any status bit has its matching enable bit set. Software reaches the registers through a flat byte-index port with one-cycle registered read data. The block has no ADC, tachometer counter, PWM generator or bus protocol engine. It takes their results as inputs.

Top module: `hwmon_irq_ctrl`

## Requirements
- R1: After reset, every status register and every enable register reads 00h, `smi_n` is 1, and `reg_rdata` is 00h.
- R2: Register index 31h holds the voltage status. Bit i (i < NV) sets when channel i's code is strictly above its high limit or strictly below its low limit. A code equal to either limit does not set it.
- R3: Bit NV of index 31h is the temperature status. An internal alarm sets when the code is strictly above the high limit and clears only when the code is strictly below the hysteresis limit. While the alarm is on, the status bit is set again every cycle.
- R4: Index 34h holds the fan status, with bit 0 for fan 1 and bit 1 for fan 2. A fan's bit sets once the condition "count strictly above expected AND PWM at full duty" has held on more than `fault_time` consecutive clock edges. Any gap in the condition restarts the count, and a count equal to the expected value never qualifies.
- R5: Writing 1 to a bit of index 31h or 34h clears that bit. Writing 0 leaves it unchanged.
- R6: If a set event and a write-1 clear reach the same status bit in the same cycle, the bit ends up set.
- R7: `smi_n` is 0 one cycle after any status bit has its matching enable bit set (index 32h for voltage and temperature, index 33h for fans), and 1 otherwise. A status bit whose enable is 0 never pulls `smi_n` low.
- R8: Reserved bits (above bit NV at 31h/32h, above bit NF-1 at 33h/34h) read 0 and ignore writes. Indices outside 31h to 34h read 00h and ignore writes.
- R9: The enable registers at 32h and 33h read back the value last written to their implemented bits.
- R10: `reg_rdata` shows the register chosen by `reg_addr` one clock edge after the address is presented, including back-to-back reads of different indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vin_code | input | NV*DW | Voltage channel codes, channel i at bits [i*DW +: DW] |
| vin_hi_lim | input | NV*DW | Per-channel high limits |
| vin_lo_lim | input | NV*DW | Per-channel low limits |
| tmp_code | input | DW | Temperature code |
| tmp_hi_lim | input | DW | Temperature high limit |
| tmp_hyst_lim | input | DW | Temperature hysteresis (release) limit |
| fan_count | input | NF*CW | Measured tachometer counts per fan |
| fan_expect | input | NF*CW | Expected counts per fan |
| fan_pwm_full | input | NF | Per-fan flag: PWM output at full duty |
| fault_time | input | TW | Fault window in clock cycles |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| smi_n | output | 1 | Active-low interrupt, registered |

## Verification
A hardware set and a software write-1 clear can reach the same status bit in one cycle. The bench provokes this for a voltage channel by driving an out-of-window code during exactly the cycle whose edge also commits a write of 1 to that bit. It then restores the code and reads the register: the bit must still read 1. The bench does the same for the temperature channel while its alarm is held between the two limits, so each clear is overridden at once and the readback must still show the bit.

// File: rtl/hwmon_irq_pkg.sv
package hwmon_irq_pkg;
  localparam int REG_W = 8;

  localparam logic [REG_W-1:0] IDX_VSTS = 8'h31;
  localparam logic [REG_W-1:0] IDX_VEN  = 8'h32;
  localparam logic [REG_W-1:0] IDX_FEN  = 8'h33;
  localparam logic [REG_W-1:0] IDX_FSTS = 8'h34;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_VSTS,
    SEL_VEN,
    SEL_FEN,
    SEL_FSTS
  } reg_sel_e;

  function automatic reg_sel_e decode_idx(input logic [REG_W-1:0] idx);
    case (idx)
      IDX_VSTS: return SEL_VSTS;
      IDX_VEN:  return SEL_VEN;
      IDX_FEN:  return SEL_FEN;
      IDX_FSTS: return SEL_FSTS;
      default:  return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/hwmon_win_detect.sv
module hwmon_win_detect #(
  parameter int NV = 4,
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NV*DW-1:0] vin_code,
  input  logic [NV*DW-1:0] vin_hi_lim,
  input  logic [NV*DW-1:0] vin_lo_lim,
  input  logic [DW-1:0]   tmp_code,
  input  logic [DW-1:0]   tmp_hi_lim,
  input  logic [DW-1:0]   tmp_hyst_lim,
  output logic [NV:0]     evt_o
);
  logic tmp_alarm_q;

  genvar gi;
  generate
    for (gi = 0; gi < NV; gi++) begin : g_chan
      logic [DW-1:0] code, hi, lo;
      assign code = vin_code[gi*DW +: DW];
      assign hi   = vin_hi_lim[gi*DW +: DW];
      assign lo   = vin_lo_lim[gi*DW +: DW];
      assign evt_o[gi] = (code > hi) || (code < lo);
    end
  endgenerate

  // temperature alarm with hysteresis band
  always_ff @(posedge clk) begin
    if (rst) begin
      tmp_alarm_q <= 1'b0;
    end else if (tmp_code > tmp_hi_lim) begin
      tmp_alarm_q <= 1'b1;
    end else if (tmp_code < tmp_hyst_lim) begin
      tmp_alarm_q <= 1'b0;
    end
  end

  assign evt_o[NV] = tmp_alarm_q;

  AST_TEMP_BAND_HOLD: assert property (@(posedge clk) disable iff (rst)
    (tmp_code <= tmp_hi_lim && tmp_code >= tmp_hyst_lim) |=> $stable(tmp_alarm_q)); // R3
  AST_TEMP_RAISE: assert property (@(posedge clk) disable iff (rst)
    (tmp_code > tmp_hi_lim) |=> tmp_alarm_q); // R3
endmodule

// File: rtl/hwmon_fan_fault.sv
module hwmon_fan_fault #(
  parameter int CW = 8,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] expect_i,
  input  logic          pwm_full_i,
  input  logic [TW-1:0] fault_time_i,
  output logic          fault_o
);
  logic          cond;
  logic [TW-1:0] held_q;

  assign cond = pwm_full_i && (count_i > expect_i);

  // consecutive-cycle counter, saturating, restarts on any gap
  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      held_q <= '0;
    end else if (held_q != {TW{1'b1}}) begin
      held_q <= held_q + 1'b1;
    end
  end

  assign fault_o = cond && (held_q >= fault_time_i);

  AST_FAN_RESTART: assert property (@(posedge clk) disable iff (rst)
    !cond |=> held_q == '0); // R4
  AST_FAN_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (cond && !fault_o) |=> held_q == $past(held_q) + 1'b1); // R4
endmodule

// File: rtl/hwmon_sts_bank.sv
module hwmon_sts_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  output logic [N-1:0] sts_o,
  output logic [N-1:0] en_o,
  output logic         hit_o
);
  logic [N-1:0] sts_q, en_q;

  genvar gb;
  generate
    for (gb = 0; gb < N; gb++) begin : g_bit
      always_ff @(posedge clk) begin
        if (rst) begin
          sts_q[gb] <= 1'b0;
        end else if (set_i[gb]) begin
          sts_q[gb] <= 1'b1;
        end else if (clr_i[gb]) begin
          sts_q[gb] <= 1'b0;
        end
      end

      AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i[gb] |=> sts_q[gb]); // R6
      AST_W1C: assert property (@(posedge clk) disable iff (rst)
        (sts_q[gb] && !set_i[gb] && clr_i[gb]) |=> !sts_q[gb]); // R5
      AST_NO_SPUR_SET: assert property (@(posedge clk) disable iff (rst)
        (!sts_q[gb] && !set_i[gb]) |=> !sts_q[gb]); // R5
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_wdata;
    end
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;
  assign hit_o = |(sts_q & en_q);

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (rst)
    en_we |=> en_q == $past(en_wdata)); // R9
endmodule

// File: rtl/hwmon_irq_ctrl.sv
module hwmon_irq_ctrl
  import hwmon_irq_pkg::*;
#(
  parameter int NV = 4,
  parameter int DW = 8,
  parameter int NF = 2,
  parameter int CW = 8,
  parameter int TW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NV*DW-1:0] vin_code,
  input  logic [NV*DW-1:0] vin_hi_lim,
  input  logic [NV*DW-1:0] vin_lo_lim,
  input  logic [DW-1:0]    tmp_code,
  input  logic [DW-1:0]    tmp_hi_lim,
  input  logic [DW-1:0]    tmp_hyst_lim,
  input  logic [NF*CW-1:0] fan_count,
  input  logic [NF*CW-1:0] fan_expect,
  input  logic [NF-1:0]    fan_pwm_full,
  input  logic [TW-1:0]    fault_time,
  input  logic [7:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             smi_n
);
  localparam int VB = NV + 1;
  localparam logic [REG_W-1:0] VMASK = REG_W'((1 << VB) - 1);
  localparam logic [REG_W-1:0] FMASK = REG_W'((1 << NF) - 1);

  reg_sel_e      sel;
  logic [VB-1:0] v_evt, v_clr, v_sts, v_en;
  logic [NF-1:0] f_evt, f_clr, f_sts, f_en;
  logic          v_hit, f_hit;
  logic [7:0]    rd_mux;

  assign sel = decode_idx(reg_addr);

  hwmon_win_detect #(.NV(NV), .DW(DW)) u_win (
    .clk          (clk),
    .rst          (rst),
    .vin_code     (vin_code),
    .vin_hi_lim   (vin_hi_lim),
    .vin_lo_lim   (vin_lo_lim),
    .tmp_code     (tmp_code),
    .tmp_hi_lim   (tmp_hi_lim),
    .tmp_hyst_lim (tmp_hyst_lim),
    .evt_o        (v_evt)
  );

  genvar gf;
  generate
    for (gf = 0; gf < NF; gf++) begin : g_fan
      hwmon_fan_fault #(.CW(CW), .TW(TW)) u_fan (
        .clk          (clk),
        .rst          (rst),
        .count_i      (fan_count[gf*CW +: CW]),
        .expect_i     (fan_expect[gf*CW +: CW]),
        .pwm_full_i   (fan_pwm_full[gf]),
        .fault_time_i (fault_time),
        .fault_o      (f_evt[gf])
      );
    end
  endgenerate

  assign v_clr = (reg_wr && sel == SEL_VSTS) ? reg_wdata[VB-1:0] : '0;
  assign f_clr = (reg_wr && sel == SEL_FSTS) ? reg_wdata[NF-1:0] : '0;

  hwmon_sts_bank #(.N(VB)) u_vbank (
    .clk      (clk),
    .rst      (rst),
    .set_i    (v_evt),
    .clr_i    (v_clr),
    .en_we    (reg_wr && sel == SEL_VEN),
    .en_wdata (reg_wdata[VB-1:0]),
    .sts_o    (v_sts),
    .en_o     (v_en),
    .hit_o    (v_hit)
  );

  hwmon_sts_bank #(.N(NF)) u_fbank (
    .clk      (clk),
    .rst      (rst),
    .set_i    (f_evt),
    .clr_i    (f_clr),
    .en_we    (reg_wr && sel == SEL_FEN),
    .en_wdata (reg_wdata[NF-1:0]),
    .sts_o    (f_sts),
    .en_o     (f_en),
    .hit_o    (f_hit)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_VSTS: rd_mux[VB-1:0] = v_sts;
      SEL_VEN:  rd_mux[VB-1:0] = v_en;
      SEL_FEN:  rd_mux[NF-1:0] = f_en;
      SEL_FSTS: rd_mux[NF-1:0] = f_sts;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      smi_n     <= 1'b1;
    end else begin
      reg_rdata <= rd_mux;
      smi_n     <= !(v_hit || f_hit);
    end
  end

  AST_SMI_LOW: assert property (@(posedge clk) disable iff (rst)
    (v_hit || f_hit) |=> !smi_n); // R7
  AST_SMI_HIGH: assert property (@(posedge clk) disable iff (rst)
    !(v_hit || f_hit) |=> smi_n); // R7
  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(reg_addr) == IDX_FSTS || $past(reg_addr) == IDX_FEN))
      |-> reg_rdata[7:NF] == '0); // R8
  AST_RSVD_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == IDX_VEN) |=>
      REG_W'(v_en) == ($past(reg_wdata) & VMASK)); // R8
  AST_FEN_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == IDX_FEN) |=>
      REG_W'(f_en) == ($past(reg_wdata) & FMASK)); // R8
endmodule

// File: tb/hwmon_irq_ctrl_tb.sv
module hwmon_irq_ctrl_tb;
  localparam int NV = 4, DW = 8, NF = 2, CW = 8, TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] vin [NV];
  logic [DW-1:0] tmp_code = 8'h50;
  logic [CW-1:0] fcnt [NF];
  logic [NF-1:0] fan_pwm_full = '0;
  logic [TW-1:0] fault_time = 8'd5;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_rdata;
  logic smi_n;

  logic [NV*DW-1:0] vin_code;
  logic [NF*CW-1:0] fan_count;
  assign vin_code  = {vin[3], vin[2], vin[1], vin[0]};
  assign fan_count = {fcnt[1], fcnt[0]};

  always #10 clk = ~clk;

  hwmon_irq_ctrl #(.NV(NV), .DW(DW), .NF(NF), .CW(CW), .TW(TW)) u_dut (
    .clk          (clk),
    .rst          (rst),
    .vin_code     (vin_code),
    .vin_hi_lim   ({NV{8'hC0}}),
    .vin_lo_lim   ({NV{8'h40}}),
    .tmp_code     (tmp_code),
    .tmp_hi_lim   (8'h60),
    .tmp_hyst_lim (8'h58),
    .fan_count    (fan_count),
    .fan_expect   ({NF{8'd200}}),
    .fan_pwm_full (fan_pwm_full),
    .fault_time   (fault_time),
    .reg_addr     (reg_addr),
    .reg_wr       (reg_wr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .smi_n        (smi_n)
  );

  typedef struct {
    int         cyc;
    logic [7:0] exp;
    string      tag;
  } sb_item_t;

  sb_item_t sbq[$];
  int cyc = 0, total = 0, bad = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compares read data against queued expectations
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc == cyc) begin
      sb_item_t it;
      it = sbq.pop_front();
      total++;
      if (reg_rdata !== it.exp) begin
        bad++;
        $display("FAIL %s: rdata got %h expected %h", it.tag, reg_rdata, it.exp);
      end
    end
  end

  task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    sbq.push_back('{cyc + 1, e, tag});
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_smi(input logic e, input string tag);
    total++;
    if (smi_n !== e) begin
      bad++;
      $display("FAIL %s: smi_n got %b expected %b", tag, smi_n, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NV; i++) vin[i] = 8'h80;
    for (int i = 0; i < NF; i++) fcnt[i] = 8'd100;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    total++;
    if (reg_rdata !== 8'h00) begin
      bad++; $display("FAIL R1: rdata got %h expected 00", reg_rdata);
    end
    chk_smi(1'b1, "R1");
    rd(8'h31, 8'h00, "R1 vsts");
    rd(8'h32, 8'h00, "R1 ven");
    rd(8'h33, 8'h00, "R1 fen");
    rd(8'h34, 8'h00, "R1 fsts");

    // R9 / R8 enables read back implemented bits only
    wr(8'h32, 8'hFF);
    wr(8'h33, 8'hFF);
    rd(8'h32, 8'h1F, "R9 ven readback");
    rd(8'h33, 8'h03, "R8 fen reserved");   // R10 back-to-back
    rd(8'h32, 8'h1F, "R10 back-to-back");
    wr(8'h32, 8'h00);
    wr(8'h33, 8'h00);
    rd(8'h32, 8'h00, "R9 ven cleared");
    wr(8'h30, 8'hFF);
    rd(8'h30, 8'h00, "R8 unmapped");
    rd(8'h35, 8'h00, "R8 unmapped");

    // R2 window detection
    vin[1] = 8'hD0; idle(1); vin[1] = 8'h80;
    vin[3] = 8'h30; idle(1); vin[3] = 8'h80;
    vin[0] = 8'hC0; vin[2] = 8'h40; idle(1); vin[0] = 8'h80; vin[2] = 8'h80;
    idle(1);
    rd(8'h31, 8'h0A, "R2 window");
    chk_smi(1'b1, "R7 disabled status");

    // R7 enable gating
    wr(8'h32, 8'h02);
    idle(1);
    chk_smi(1'b0, "R7 enabled status");

    // R5 write-one-to-clear
    wr(8'h31, 8'h08);
    rd(8'h31, 8'h02, "R5 clear one bit");
    wr(8'h31, 8'h00);
    rd(8'h31, 8'h02, "R5 zero write");
    wr(8'h31, 8'h02);
    rd(8'h31, 8'h00, "R5 clear");
    chk_smi(1'b1, "R7 deassert");

    // R6 set and clear in the same cycle
    reg_addr = 8'h31; reg_wdata = 8'h01; reg_wr = 1'b1; vin[0] = 8'hD0;
    @(negedge clk);
    reg_wr = 1'b0; vin[0] = 8'h80;
    idle(1);
    rd(8'h31, 8'h01, "R6 set wins");
    wr(8'h31, 8'h01);
    rd(8'h31, 8'h00, "R6 later clear");

    // R3 temperature with hysteresis
    tmp_code = 8'h70; idle(1);
    tmp_code = 8'h5C; idle(2);
    wr(8'h31, 8'h10);
    rd(8'h31, 8'h10, "R3 alarm held");
    tmp_code = 8'h50; idle(2);
    wr(8'h31, 8'h10);
    rd(8'h31, 8'h00, "R3 released");
    tmp_code = 8'h5C; idle(2);
    rd(8'h31, 8'h00, "R3 band no set");
    tmp_code = 8'h50;

    // R4 fan fault timing, fault_time = 5
    fcnt[0] = 8'd250; fan_pwm_full[0] = 1'b1; idle(5); fan_pwm_full[0] = 1'b0;
    idle(1);
    rd(8'h34, 8'h00, "R4 short hold");
    fan_pwm_full[0] = 1'b1; idle(6); fan_pwm_full[0] = 1'b0;
    idle(1);
    rd(8'h34, 8'h01, "R4 fault fan1");
    fcnt[1] = 8'd250;
    fan_pwm_full[1] = 1'b1; idle(3); fan_pwm_full[1] = 1'b0; idle(1);
    fan_pwm_full[1] = 1'b1; idle(3); fan_pwm_full[1] = 1'b0; idle(1);
    rd(8'h34, 8'h01, "R4 gap restarts");
    fcnt[1] = 8'd200;
    fan_pwm_full[1] = 1'b1; idle(20); fan_pwm_full[1] = 1'b0; idle(1);
    rd(8'h34, 8'h01, "R4 equal count");
    fcnt[1] = 8'd201;
    fan_pwm_full[1] = 1'b1; idle(10); fan_pwm_full[1] = 1'b0; idle(1);
    rd(8'h34, 8'h03, "R4 fault fan2");

    // R7 fan enable gating
    wr(8'h32, 8'h00);
    wr(8'h33, 8'h02);
    idle(1);
    chk_smi(1'b0, "R7 fan2 enabled");
    rd(8'h33, 8'h02, "R9 fen readback");
    wr(8'h34, 8'h02);
    idle(1);
    chk_smi(1'b1, "R7 fan1 disabled");
    wr(8'h34, 8'h00);
    rd(8'h34, 8'h01, "R5 zero write fan");
    wr(8'h34, 8'hFC);
    rd(8'h34, 8'h01, "R8 reserved write");
    wr(8'h34, 8'h01);
    rd(8'h34, 8'h00, "R5 fan clear");

    idle(3);
    if (sbq.size() != 0) begin
      bad++; total++;
      $display("FAIL R10: pending reads got %0d expected 0", sbq.size());
    end
    finish_run();
  end
endmodule